// File: doc/BRIEF.md
# Four-Bit Eight-Function ALU

This block is a purely combinational arithmetic and logic unit for 4-bit operands. A 3-bit operation code picks one of eight functions: four bitwise logic functions of the two operands, and four arithmetic functions. The arithmetic functions are addition, subtraction, increment and decrement.

All four arithmetic functions share one ripple-carry chain of full-adder slices, with the carry running from bit 0 up to the top bit. A per-bit operand selector decides what reaches the adder's second input: the B operand, its complement, all zeros or all ones. The carry-in is chosen at the same time. A per-bit output selector then passes either the adder sum or the logic result. No state is held, so the outputs follow the inputs within the same cycle.

Top module: `alu4_core`

## Requirements
- R1: Code 3'b000 gives res_o = a_i AND b_i, bit by bit.
- R2: Code 3'b001 gives res_o = a_i XOR b_i, bit by bit.
- R3: Code 3'b010 gives res_o = NOT (a_i XOR b_i), bit by bit.
- R4: Code 3'b011 gives res_o = a_i OR b_i, bit by bit.
- R5: For every code with op_i[2] = 0, cout_o is 0.
- R6: Code 3'b100 gives {cout_o, res_o} = a_i + b_i, unsigned, as a 5-bit result.
- R7: Code 3'b101 gives res_o = (a_i - b_i) mod 16. cout_o is 1 exactly when a_i >= b_i unsigned, meaning no borrow.
- R8: Code 3'b110 gives res_o = (a_i + 1) mod 16. cout_o is 1 only when a_i = 4'b1111.
- R9: Code 3'b111 gives res_o = (a_i - 1) mod 16. cout_o is 1 unless a_i = 4'b0000.
- R10: For codes 3'b110 and 3'b111, the value of b_i has no effect on res_o or cout_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| op_i | input | 3 | Operation code |
| res_o | output | 4 | Result |
| cout_o | output | 1 | Carry out of the top adder slice; 0 for logic codes |

## Verification
The carry-out and the wrapped result both come from the same adder evaluation, so each check compares them together. This matters most where they interact: incrementing 4'b1111 must give 4'b0000 with cout_o = 1, and decrementing 4'b0000 must give 4'b1111 with cout_o = 0. The operand selector and the output selector both switch on the same code, so the bench runs every code over all 256 operand pairs, back to back. Each expected value comes from plain integer arithmetic. For increment and decrement, b_i is swept while a_i stays fixed, and the bench checks that the outputs do not move.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_XOR  = 3'b001,
    OP_XNOR = 3'b010,
    OP_OR   = 3'b011,
    OP_ADD  = 3'b100,
    OP_SUB  = 3'b101,
    OP_INC  = 3'b110,
    OP_DEC  = 3'b111
  } op_e;

  // operand selector codes
  typedef enum logic [1:0] {
    OPND_B    = 2'd0,
    OPND_NB   = 2'd1,
    OPND_ZERO = 2'd2,
    OPND_ONES = 2'd3
  } opnd_e;
endpackage

// File: rtl/alu4_fa.sv
module alu4_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p;
  assign p   = a_i ^ b_i;
  assign s_o = p ^ c_i;
  assign c_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/alu4_opnd_mux.sv
module alu4_opnd_mux #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]     b_i,
  input  alu4_pkg::opnd_e      sel_i,
  output logic [WIDTH-1:0]     opnd_o
);
  import alu4_pkg::*;
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (sel_i)
        OPND_B:    opnd_o[i] = b_i[i];
        OPND_NB:   opnd_o[i] = ~b_i[i];
        OPND_ZERO: opnd_o[i] = 1'b0;
        default:   opnd_o[i] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/alu4_logic.sv
module alu4_logic #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       fn_i,
  output logic [WIDTH-1:0] y_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (fn_i)
        2'd0:    y_o[i] = a_i[i] & b_i[i];
        2'd1:    y_o[i] = a_i[i] ^ b_i[i];
        2'd2:    y_o[i] = ~(a_i[i] ^ b_i[i]);
        default: y_o[i] = a_i[i] | b_i[i];
      endcase
    end
  end
endmodule

// File: rtl/alu4_core.sv
module alu4_core #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  import alu4_pkg::*;

  opnd_e            opnd_sel;
  logic             cin;
  logic [WIDTH-1:0] opnd;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] lres;
  logic [WIDTH:0]   carry;

  always_comb begin
    unique case (op_i[1:0])
      2'd0:    opnd_sel = OPND_B;
      2'd1:    opnd_sel = OPND_NB;
      2'd2:    opnd_sel = OPND_ZERO;
      default: opnd_sel = OPND_ONES;
    endcase
  end
  // carry-in set for subtract and increment
  assign cin = op_i[2] & (op_i[1] ^ op_i[0]);

  alu4_opnd_mux #(.WIDTH(WIDTH)) u_opnd (
    .b_i    (b_i),
    .sel_i  (opnd_sel),
    .opnd_o (opnd)
  );

  assign carry[0] = cin;
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu4_fa u_fa (
      .a_i (a_i[i]),
      .b_i (opnd[i]),
      .c_i (carry[i]),
      .s_o (sum[i]),
      .c_o (carry[i+1])
    );
  end

  alu4_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .fn_i (op_i[1:0]),
    .y_o  (lres)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_out
    assign res_o[i] = op_i[2] ? sum[i] : lres[i];
  end
  assign cout_o = op_i[2] & carry[WIDTH];
endmodule

// File: rtl/alu4_core_chk.sv
module alu4_core_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] res_o,
  input logic             cout_o
);
  logic [WIDTH:0] a_x, b_x, full;
  assign a_x = {1'b0, a_i};
  assign b_x = {1'b0, b_i};
  assign full = {cout_o, res_o};

  always_comb begin
    if (op_i == 3'b000) assert_and_R1: assert (res_o == (a_i & b_i));
    if (op_i == 3'b001) assert_xor_R2: assert (res_o == (a_i ^ b_i));
    if (op_i == 3'b010) assert_xnor_R3: assert (res_o == ~(a_i ^ b_i));
    if (op_i == 3'b011) assert_or_R4: assert (res_o == (a_i | b_i));
    if (!op_i[2]) assert_logic_cout_R5: assert (!cout_o);
    if (op_i == 3'b100) assert_add_R6: assert (full == a_x + b_x);
    if (op_i == 3'b101) assert_sub_R7: assert (res_o == WIDTH'(a_i - b_i) && cout_o == (a_i >= b_i));
    if (op_i == 3'b110) assert_inc_R8: assert (res_o == WIDTH'(a_i + 1'b1) && cout_o == (&a_i));
    if (op_i == 3'b111) assert_dec_R9: assert (res_o == WIDTH'(a_i - 1'b1) && cout_o == (|a_i));
  end
endmodule

bind alu4_core alu4_core_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .op_i   (op_i),
  .res_o  (res_o),
  .cout_o (cout_o)
);

// File: tb/alu4_core_bench.sv
`timescale 1ns/1ps
module alu4_core_bench;
  logic       clk = 1'b0;
  logic [3:0] a, b, res;
  logic [2:0] op;
  logic       cout;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  alu4_core u_alu4_core (
    .a_i    (a),
    .b_i    (b),
    .op_i   (op),
    .res_o  (res),
    .cout_o (cout)
  );

  // {op, a, b, exp_res, exp_cout}
  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    {3'b000, 4'hC, 4'hA, 4'h8, 1'b0},
    {3'b001, 4'hC, 4'hA, 4'h6, 1'b0},
    {3'b010, 4'hC, 4'hA, 4'h9, 1'b0},
    {3'b011, 4'hC, 4'hA, 4'hE, 1'b0},
    {3'b100, 4'hF, 4'h1, 4'h0, 1'b1},
    {3'b101, 4'h3, 4'h5, 4'hE, 1'b0},
    {3'b101, 4'h5, 4'h5, 4'h0, 1'b1},
    {3'b110, 4'hF, 4'h7, 4'h0, 1'b1},
    {3'b111, 4'h0, 4'h9, 4'hF, 1'b0},
    {3'b111, 4'h1, 4'h0, 4'h0, 1'b1}
  };

  task automatic apply(input logic [2:0] o, input logic [3:0] x, input logic [3:0] y);
    @(negedge clk);
    op = o; a = x; b = y;
    #5;
  endtask

  task automatic check(input string req, input logic [3:0] er, input logic ec);
    n_chk++;
    if (res !== er || cout !== ec) begin
      n_err++;
      $display("FAIL %s op=%b a=%h b=%h got res=%h cout=%b exp res=%h cout=%b",
               req, op, a, b, res, cout, er, ec);
    end
  endtask

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100: return "R6";
      3'b101: return "R7";
      3'b110: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    op = '0; a = '0; b = '0;
    // table vectors
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][15:13], VEC[i][12:9], VEC[i][8:5]);
      check(req_of(VEC[i][15:13]), VEC[i][4:1], VEC[i][0]);
    end
    // exhaustive sweep against integer reference
    for (int o = 0; o < 8; o++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          int r; logic c;
          case (o)
            0: begin r = x & y; c = 0; end
            1: begin r = x ^ y; c = 0; end
            2: begin r = ~(x ^ y) & 15; c = 0; end
            3: begin r = x | y; c = 0; end
            4: begin r = x + y; c = (r > 15); end
            5: begin r = x - y + 16; c = (x >= y); end
            6: begin r = x + 1; c = (x == 15); end
            default: begin r = x + 15; c = (x != 0); end
          endcase
          apply(3'(o), 4'(x), 4'(y));
          check(o < 4 ? "R1-4/R5" : req_of(3'(o)), 4'(r & 15), c);
        end
      end
    end
    // R5: logic codes never carry, even with all-ones operands
    apply(3'b011, 4'hF, 4'hF); check("R5", 4'hF, 1'b0);
    apply(3'b000, 4'hF, 4'hF); check("R5", 4'hF, 1'b0);
    // R10: b sweep under INC/DEC leaves outputs unchanged
    for (int y = 0; y < 16; y++) begin
      apply(3'b110, 4'h9, 4'(y)); check("R10", 4'hA, 1'b0);
      apply(3'b111, 4'h9, 4'(y)); check("R10", 4'h8, 1'b1);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule